// File: doc/BRIEF.md
# Synchronous-Read Register File with Write Forwarding and Debug Access

This block stores the 64 architected operand registers of a processor core, 64 bits each. Indices 0 to 31 hold the general-purpose registers and indices 32 to 63 hold the floating-point registers. It has three read ports, A, B and C. The decode stage presents the three read addresses one cycle before the execute stage needs the operands, so the storage array can be a registered block RAM. All three addresses are sent every cycle, even when the instruction does not use all three operands. One write port from writeback updates the array.

The block keeps a copy of the last write: its enable, address and data. A read whose address matches that copy returns the new data instead of the value the array gave before the write landed. While the pipeline is stalled, the addresses latched in the previous cycle are read again, and the new inputs are ignored. A debug requester can read any register. It borrows port B, but only in cycles where decode has no valid instruction or the instruction does not use its B operand.

The debug controller is a small state machine with three states. Idle waits for a request. On a request it goes straight to Respond when port B is free, and to Wait when it is not. Wait holds the captured address and moves to Respond in the first cycle port B is free. Respond drives the acknowledge for one cycle and always returns to Idle.

Top module: `rf_sync_regfile`

## Requirements
- R1: Every one of the 64 entries holds its own value: GPRs sit at addresses 0 to 31 and FPRs at addresses 32 to 63, and a value written to one entry is read back from that entry only.
- R2: Read data for an address presented in a cycle without stall appears on that port's output in the following cycle and stays there until the next clock edge.
- R3: While `stall` is high, each port reads again the address it used in the previous cycle. Addresses presented during the stall have no effect on the outputs.
- R4: When a read address presented in a cycle equals the write address of a write enabled in that same cycle, the read returns the newly written data on every port.
- R5: A write address presented with `wr_en` low changes no entry and causes no forwarding: a matching read returns the previously stored value.
- R6: The three ports are independent: each returns its own address's data, also when two or three of them name the same register.
- R7: A debug request made while port B is free (`rd_valid` low or `rd_b_used` low) is served at once. In the next cycle `dbg_ack` is high and `dbg_data` holds the requested register.
- R8: While `rd_valid` and `rd_b_used` are both high, a debug request stays pending, port B keeps serving the instruction, and no acknowledge is given. The request is served in the first free cycle and acknowledged one cycle after it.
- R9: After reset, all read outputs and `dbg_data` are zero and `dbg_ack` is low. `dbg_ack` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Decode presents a valid instruction this cycle |
| rd_b_used | input | 1 | The instruction reads its B operand |
| rd_addr_a | input | 6 | Read address, port A |
| rd_addr_b | input | 6 | Read address, port B |
| rd_addr_c | input | 6 | Read address, port C |
| stall | input | 1 | Reuse the previously latched read addresses |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 64 | Write data |
| dbg_req | input | 1 | Debug read request |
| dbg_addr | input | 6 | Debug read address |
| rd_data_a | output | 64 | Read data, port A |
| rd_data_b | output | 64 | Read data, port B |
| rd_data_c | output | 64 | Read data, port C |
| dbg_data | output | 64 | Debug read data, valid with `dbg_ack` |
| dbg_ack | output | 1 | One-cycle acknowledge of a debug read |

## Verification
The assertions check four things on every cycle. Forwarding returns the written word on ports A and C whenever the read and the write share an address (R4). Outputs stay stable across a stall when no write occurred (R3). No acknowledge follows a cycle in which port B was busy (R8). The acknowledge never lasts two cycles (R9). The bench scenarios are needed for what depends on stored contents: that every entry keeps its own value (R1), the one-cycle read latency (R2), that a disabled write leaves the data alone (R5), port independence (R6), and the debug data and the exact cycle it is returned in (R7, R8).

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int NUM_RD = 3;
    localparam int PORT_A = 0;
    localparam int PORT_B = 1;
    localparam int PORT_C = 2;

    typedef enum logic [1:0] {
        DBG_IDLE = 2'd0,
        DBG_WAIT = 2'd1,
        DBG_RESP = 2'd2
    } dbg_state_e;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DATA_W  = 64,
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 6,
    parameter int NRD     = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Each port reads the array before this edge's write (read-first).
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[p] <= '0;
            end else begin
                rdata[p] <= mem[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/rf_fwd_mux.sv
module rf_fwd_mux #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 6
) (
    input  logic [DATA_W-1:0] ram_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wq_en,
    input  logic [ADDR_W-1:0] wq_addr,
    input  logic [DATA_W-1:0] wq_data,
    output logic [DATA_W-1:0] port_data
);
    always_comb begin
        if (wq_en && (wq_addr == rd_addr)) begin
            port_data = wq_data;
        end else begin
            port_data = ram_data;
        end
    end
endmodule

// File: rtl/rf_dbg_ctrl.sv
module rf_dbg_ctrl
    import rf_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              port_free,
    output logic              steal,
    output logic [ADDR_W-1:0] steal_addr,
    output logic              ack
);
    dbg_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DBG_IDLE;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == DBG_IDLE && req) begin
                addr_q <= req_addr;
            end
        end
    end

    always_comb begin
        state_nx   = state;
        steal      = 1'b0;
        steal_addr = addr_q;
        ack        = 1'b0;
        unique case (state)
            DBG_IDLE: begin
                steal_addr = req_addr;
                if (req) begin
                    steal    = port_free;
                    state_nx = port_free ? DBG_RESP : DBG_WAIT;
                end
            end
            DBG_WAIT: begin
                if (port_free) begin
                    steal    = 1'b1;
                    state_nx = DBG_RESP;
                end
            end
            DBG_RESP: begin
                ack      = 1'b1;
                state_nx = DBG_IDLE;
            end
            default: begin
                state_nx = DBG_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/rf_sync_regfile.sv
module rf_sync_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int ENTRIES = 64,
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              rd_b_used,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic [ADDR_W-1:0] rd_addr_c,
    input  logic              stall,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dbg_req,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic [DATA_W-1:0] rd_data_c,
    output logic [DATA_W-1:0] dbg_data,
    output logic              dbg_ack
);
    logic [NUM_RD-1:0][ADDR_W-1:0] addr_in, addr_eff, addr_q;
    logic [NUM_RD-1:0][DATA_W-1:0] ram_q, port_q;
    logic                          wq_en;
    logic [ADDR_W-1:0]             wq_addr;
    logic [DATA_W-1:0]             wq_data;
    logic                          port_free, dbg_steal;
    logic [ADDR_W-1:0]             dbg_rd_addr;

    assign addr_in   = {rd_addr_c, rd_addr_b, rd_addr_a};
    assign port_free = !rd_valid || !rd_b_used;

    always_comb begin
        for (int p = 0; p < NUM_RD; p++) begin
            addr_eff[p] = stall ? addr_q[p] : addr_in[p];
        end
        if (dbg_steal) begin
            addr_eff[PORT_B] = dbg_rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wq_en   <= 1'b0;
            wq_addr <= '0;
            wq_data <= '0;
        end else begin
            addr_q  <= addr_eff;
            wq_en   <= wr_en;
            wq_addr <= wr_addr;
            wq_data <= wr_data;
        end
    end

    rf_store #(
        .DATA_W(DATA_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .NRD(NUM_RD)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(addr_eff), .rdata(ram_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_fwd
        rf_fwd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fwd (
            .ram_data(ram_q[p]), .rd_addr(addr_q[p]),
            .wq_en(wq_en), .wq_addr(wq_addr), .wq_data(wq_data),
            .port_data(port_q[p])
        );
    end

    rf_dbg_ctrl #(.ADDR_W(ADDR_W)) u_dbg (
        .clk(clk), .rst_n(rst_n), .req(dbg_req), .req_addr(dbg_addr),
        .port_free(port_free), .steal(dbg_steal), .steal_addr(dbg_rd_addr),
        .ack(dbg_ack)
    );

    assign rd_data_a = port_q[PORT_A];
    assign rd_data_b = port_q[PORT_B];
    assign rd_data_c = port_q[PORT_C];
    assign dbg_data  = port_q[PORT_B];
endmodule

// File: rtl/rf_sync_regfile_chk.sv
module rf_sync_regfile_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_c,
    input logic              rd_valid,
    input logic              rd_b_used,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_c,
    input logic              dbg_ack
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r4_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(wr_en) && !$past(stall) && $past(rd_addr_a) == $past(wr_addr))
        |-> rd_data_a == $past(wr_data));

    a_r4_fwd_c: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(wr_en) && !$past(stall) && $past(rd_addr_c) == $past(wr_addr))
        |-> rd_data_c == $past(wr_data));

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(stall) && !$past(wr_en) && !$past(wr_en, 2))
        |-> $stable(rd_data_a) && $stable(rd_data_c));

    a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(rd_valid && rd_b_used)) |-> !dbg_ack);

    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ack |=> !dbg_ack);
endmodule

bind rf_sync_regfile rf_sync_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rf_sync_regfile_test.sv
module rf_sync_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0, rd_b_used = 1'b0, stall = 1'b0, wr_en = 1'b0, dbg_req = 1'b0;
    logic [5:0]  rd_addr_a = '0, rd_addr_b = '0, rd_addr_c = '0, wr_addr = '0, dbg_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data_a, rd_data_b, rd_data_c, dbg_data;
    logic        dbg_ack;

    always #2 clk = ~clk;

    rf_sync_regfile uut (.*);

    typedef struct {
        int          due;
        int          kind;
        logic [63:0] val;
        string       tag;
    } item_t;

    item_t       sbq[$];
    logic [63:0] model [64];
    bit          known [64];
    logic [5:0]  held [3];
    logic [5:0]  dadr_m;
    int          bst = 0;
    int          cyc = 0;
    int          checks = 0;
    int          bad = 0;
    bit          done = 0;

    function automatic logic [63:0] pat(input int i);
        return 64'hF00D_0000_0000_0000 ^ (64'(i) * 64'h0001_0203_0405_0607) ^ 64'(i);
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic push(input int kind, input logic [63:0] v, input string tag);
        item_t it;
        it.due = cyc + 1; it.kind = kind; it.val = v; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic step(input bit v, input bit bu, input bit st,
                        input logic [5:0] a, input logic [5:0] b, input logic [5:0] c,
                        input bit we, input logic [5:0] wa, input logic [63:0] wd,
                        input bit dq, input logic [5:0] da, input string tag);
        logic [5:0] eff [3];
        logic [5:0] ins [3];
        bit free, steal;
        @(negedge clk);
        rd_valid = v; rd_b_used = bu; stall = st;
        rd_addr_a = a; rd_addr_b = b; rd_addr_c = c;
        wr_en = we; wr_addr = wa; wr_data = wd;
        dbg_req = dq; dbg_addr = da;
        ins[0] = a; ins[1] = b; ins[2] = c;
        free = !v || !bu;
        steal = 0;
        if (bst == 0) begin
            if (dq) begin
                dadr_m = da;
                steal = free;
                bst = free ? 2 : 1;
            end
        end else if (bst == 1) begin
            if (free) begin
                steal = 1;
                bst = 2;
            end
        end else begin
            bst = 0;
        end
        for (int p = 0; p < 3; p++) begin
            eff[p] = st ? held[p] : ins[p];
        end
        if (steal) eff[1] = dadr_m;
        for (int p = 0; p < 3; p++) begin
            held[p] = eff[p];
            if (we && wa == eff[p]) begin
                push(p, wd, tag);
                if (p == 1 && steal) push(4, wd, tag);
            end else if (known[eff[p]]) begin
                push(p, model[eff[p]], tag);
                if (p == 1 && steal) push(4, model[eff[p]], tag);
            end
        end
        push(3, 64'(steal), tag);
        if (we) begin
            model[wa] = wd;
            known[wa] = 1;
        end
    endtask

    task automatic idle_step(input string tag);
        step(0, 0, 0, 6'd0, 6'd0, 6'd0, 0, 6'd0, 64'd0, 0, 6'd0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // Monitor: compares due scoreboard items shortly after each edge.
    always @(posedge clk) begin
        cyc++;
        #1;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            logic [63:0] got;
            it = sbq.pop_front();
            case (it.kind)
                0: got = rd_data_a;
                1: got = rd_data_b;
                2: got = rd_data_c;
                3: got = {63'd0, dbg_ack};
                default: got = dbg_data;
            endcase
            if (it.due != cyc) begin
                checks++; bad++;
                $display("FAIL %s stale item kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.val);
            end else begin
                check($sformatf("%s kind=%0d", it.tag, it.kind), got, it.val);
            end
        end
    end

    initial begin
        #(4 * 150000);
        checks++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) known[i] = 0;
        for (int p = 0; p < 3; p++) held[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9 reset rd_data_a", rd_data_a, 64'd0);
        check("R9 reset rd_data_b", rd_data_b, 64'd0);
        check("R9 reset rd_data_c", rd_data_c, 64'd0);
        check("R9 reset dbg_data", dbg_data, 64'd0);
        check("R9 reset dbg_ack", {63'd0, dbg_ack}, 64'd0);

        // R1: fill every GPR and FPR entry
        for (int i = 0; i < 64; i++) begin
            step(0, 0, 0, 6'd0, 6'd0, 6'd0, 1, 6'(i), pat(i), 0, 6'd0, "R1");
        end
        // R1 R2 R6: read all entries with differing port patterns
        for (int i = 0; i < 64; i++) begin
            step(1, 1, 0, 6'(i), 6'(63 - i), 6'((i + 32) % 64), 0, 6'd0, 64'd0, 0, 6'd0, "R2");
        end
        // R6: all three ports on the same register
        step(1, 1, 0, 6'd17, 6'd17, 6'd17, 0, 6'd0, 64'd0, 0, 6'd0, "R6");
        step(1, 1, 0, 6'd40, 6'd40, 6'd40, 0, 6'd0, 64'd0, 0, 6'd0, "R6");
        // R4: same-cycle write and read of the same address on every port
        step(1, 1, 0, 6'd9, 6'd9, 6'd9, 1, 6'd9, 64'hDEAD_BEEF_0000_0009, 0, 6'd0, "R4");
        step(1, 1, 0, 6'd50, 6'd3, 6'd50, 1, 6'd50, 64'h1234_5678_9ABC_DEF0, 0, 6'd0, "R4");
        step(1, 1, 0, 6'd50, 6'd9, 6'd3, 0, 6'd0, 64'd0, 0, 6'd0, "R4");
        // R5: disabled write with matching address
        step(1, 1, 0, 6'd12, 6'd12, 6'd12, 0, 6'd12, 64'hBAD0_BAD0_BAD0_BAD0, 0, 6'd0, "R5");
        step(1, 1, 0, 6'd12, 6'd12, 6'd12, 0, 6'd0, 64'd0, 0, 6'd0, "R5");
        // R3: stall holds addresses, write into a held address is seen
        step(1, 1, 0, 6'd5, 6'd6, 6'd7, 0, 6'd0, 64'd0, 0, 6'd0, "R3");
        step(1, 1, 1, 6'd20, 6'd21, 6'd22, 0, 6'd0, 64'd0, 0, 6'd0, "R3");
        step(1, 1, 1, 6'd30, 6'd31, 6'd33, 1, 6'd6, 64'hCAFE_0000_0000_0006, 0, 6'd0, "R3");
        step(1, 1, 1, 6'd44, 6'd45, 6'd46, 0, 6'd0, 64'd0, 0, 6'd0, "R3");
        step(1, 1, 0, 6'd44, 6'd45, 6'd46, 0, 6'd0, 64'd0, 0, 6'd0, "R3");
        // R7: debug while no valid instruction
        step(0, 0, 0, 6'd1, 6'd2, 6'd3, 0, 6'd0, 64'd0, 1, 6'd37, "R7");
        idle_step("R7");
        // R7: debug while instruction does not use B
        step(1, 0, 0, 6'd4, 6'd8, 6'd5, 0, 6'd0, 64'd0, 1, 6'd6, "R7");
        step(1, 0, 0, 6'd4, 6'd8, 6'd5, 0, 6'd0, 64'd0, 0, 6'd0, "R7");
        // R8: debug pending while port B busy
        step(1, 1, 0, 6'd10, 6'd11, 6'd13, 0, 6'd0, 64'd0, 1, 6'd60, "R8");
        step(1, 1, 0, 6'd14, 6'd15, 6'd16, 0, 6'd0, 64'd0, 0, 6'd0, "R8");
        step(1, 1, 0, 6'd18, 6'd19, 6'd23, 1, 6'd60, 64'hFEED_FACE_0000_0060, 0, 6'd0, "R8");
        step(1, 0, 0, 6'd24, 6'd25, 6'd26, 0, 6'd0, 64'd0, 0, 6'd0, "R8");
        step(1, 1, 0, 6'd27, 6'd28, 6'd29, 0, 6'd0, 64'd0, 0, 6'd0, "R8");
        // R9: back-to-back requests never give a two-cycle acknowledge
        step(0, 0, 0, 6'd0, 6'd0, 6'd0, 0, 6'd0, 64'd0, 1, 6'd33, "R9");
        step(0, 0, 0, 6'd0, 6'd0, 6'd0, 0, 6'd0, 64'd0, 1, 6'd34, "R9");
        step(0, 0, 0, 6'd0, 6'd0, 6'd0, 0, 6'd0, 64'd0, 1, 6'd34, "R9");
        idle_step("R9");
        idle_step("R9");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule